// File: doc/BRIEF.md
# Selectable Block Check Accumulator

This block keeps a running block check over the 8-bit characters of a serial link. It has one path for transmit and one for receive, and each path has its own accumulator register. A 2-bit type input picks the algorithm at run time: longitudinal parity, which is a bytewise XOR; CRC-16; or CRC-CCITT. Every character carries an include flag. A character whose flag is clear passes through the block untouched and leaves the check value as it was. This lets control characters stay out of the check.

On the transmit side, characters arrive on a valid/ready stream and leave on a second valid/ready stream. When a character carries the append command, the finished check bytes follow it at once on the output. The input stream is held off until the last check byte has been taken. The output holds its data while the consumer keeps `tx_out_ready` low. The transmit input is ready only when no check bytes are waiting and the output register is empty or is being emptied in that cycle.

On the receive side, characters arrive on a valid/ready stream that never pushes back: `rx_ready` is always high. A character marked "expect" closes the block. The next one or two beats are taken as the received check and are compared with the accumulated value. The comparison ends in a one-cycle verdict pulse. Each path has a synchronous clear that starts a new block. A character accepted in the same cycle as the clear becomes the first character of the new block.

Top module: `bcc_engine`

## Requirements
- R1: `chk_kind` selects the check. 00 and 11 select LRC: an 8-bit XOR of the included characters, sent as one check byte. 01 selects CRC-16 with polynomial 0x8005 and 10 selects CRC-CCITT with polynomial 0x1021. Both CRCs start from zero, take each character least significant bit first (reflected form) and are sent as two bytes, low byte first. For the ASCII string "123456789", CRC-16 gives 0xBB3D and CRC-CCITT gives 0x2189.
- R2: A character with its include flag clear leaves the accumulator unchanged. On transmit it is still forwarded.
- R3: Every character accepted on the transmit input appears on `tx_out_data` unmodified and in order, one cycle after its handshake at the earliest.
- R4: A transmit character with `tx_in_send_check` set is followed directly by the check bytes, which include that character if it is included. `tx_in_ready` stays low until the last check byte has been accepted. Check bytes are never accumulated.
- R5: While `tx_out_valid` is high and `tx_out_ready` is low, `tx_out_valid` stays high and `tx_out_data` does not change.
- R6: `tx_clear` or `rx_clear` zeroes its path's accumulator. A character accepted in the same cycle starts from zero. `rx_clear` also abandons any receive comparison in progress.
- R7: A receive character with `rx_expect` set (accumulated first if included) makes the next 1 (LRC) or 2 (CRC) beats check bytes. They are compared with the accumulated value, low byte first, and are not accumulated.
- R8: In the cycle after the last check byte's beat, exactly one of `check_ok` and `check_err` is high, for one cycle only. `check_ok` means every check byte matched.
- R9: After reset, `tx_out_valid`, `check_ok` and `check_err` are low, `tx_in_ready` is high and both accumulators are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chk_kind | input | 2 | Check algorithm select |
| tx_clear | input | 1 | Start a new transmit block |
| tx_in_valid | input | 1 | Transmit character valid |
| tx_in_ready | output | 1 | Transmit character accepted |
| tx_in_data | input | 8 | Transmit character |
| tx_in_include | input | 1 | Accumulate this transmit character |
| tx_in_send_check | input | 1 | Append check bytes after this character |
| tx_out_valid | output | 1 | Outgoing byte valid |
| tx_out_ready | input | 1 | Consumer takes outgoing byte |
| tx_out_data | output | 8 | Outgoing byte |
| rx_clear | input | 1 | Start a new receive block |
| rx_valid | input | 1 | Received byte valid |
| rx_ready | output | 1 | Always high |
| rx_data | input | 8 | Received byte |
| rx_include | input | 1 | Accumulate this received character |
| rx_expect | input | 1 | Check bytes follow this character |
| check_ok | output | 1 | One-cycle pulse: check matched |
| check_err | output | 1 | One-cycle pulse: check mismatched |

## Verification
A forwarded character is registered, so it shows on `tx_out_data` one cycle after its handshake. Each check byte follows one cycle after the previous output byte is taken. The bench therefore records output bytes at the falling edge in every cycle where valid and ready are both high. It compares the whole block only after a fixed drain interval that is longer than the worst stall pattern needs. The receive verdict is registered off the edge that takes the last check byte. The bench samples it at the falling edge right after that edge, and again one cycle later to confirm that it has dropped.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  typedef enum logic [1:0] {
    KIND_LRC     = 2'b00,
    KIND_CRC16   = 2'b01,
    KIND_CCITT   = 2'b10,
    KIND_LRC_ALT = 2'b11
  } bcc_kind_t;

  function automatic logic is_crc(input logic [1:0] k);
    return (k == KIND_CRC16) || (k == KIND_CCITT);
  endfunction
endpackage

// File: rtl/bcc_step.sv
module bcc_step
  import bcc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CRC_W  = 16,
  parameter logic [CRC_W-1:0] POLY_A = 16'h8005,
  parameter logic [CRC_W-1:0] POLY_B = 16'h1021
) (
  input  logic [1:0]        kind,
  input  logic [CRC_W-1:0]  acc_in,
  input  logic [DATA_W-1:0] ch,
  output logic [CRC_W-1:0]  acc_out
);
  function automatic logic [CRC_W-1:0] mirror(input logic [CRC_W-1:0] v);
    logic [CRC_W-1:0] r;
    for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
    return r;
  endfunction

  localparam logic [CRC_W-1:0] MIR_A = mirror(POLY_A);
  localparam logic [CRC_W-1:0] MIR_B = mirror(POLY_B);

  logic [CRC_W-1:0] tap;
  logic [CRC_W-1:0] stage [DATA_W+1];

  assign tap      = (kind == KIND_CCITT) ? MIR_B : MIR_A;
  assign stage[0] = acc_in ^ {{(CRC_W-DATA_W){1'b0}}, ch};

  // one shift-and-reduce stage per input bit, least significant first
  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    assign stage[g+1] = stage[g][0] ? ((stage[g] >> 1) ^ tap) : (stage[g] >> 1);
  end

  assign acc_out = is_crc(kind) ? stage[DATA_W]
                 : {acc_in[CRC_W-1:DATA_W], acc_in[DATA_W-1:0] ^ ch};
endmodule

// File: rtl/bcc_tx.sv
module bcc_tx
  import bcc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CRC_W  = 16,
  parameter logic [CRC_W-1:0] POLY_A = 16'h8005,
  parameter logic [CRC_W-1:0] POLY_B = 16'h1021
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        kind,
  input  logic              clear,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_include,
  input  logic              in_send_check,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  localparam int NB = CRC_W / DATA_W;
  localparam int CW = $clog2(NB + 1);

  logic [CRC_W-1:0]  acc_q, hold_q, base, stepped, updated;
  logic [CW-1:0]     left_q, sel_q;
  logic              vld_q;
  logic [DATA_W-1:0] dat_q;
  logic              slot_free, take;

  assign base = clear ? '0 : acc_q;

  bcc_step #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY_A(POLY_A), .POLY_B(POLY_B)) u_step (
    .kind   (kind),
    .acc_in (base),
    .ch     (in_data),
    .acc_out(stepped)
  );

  assign updated   = in_include ? stepped : base;
  assign slot_free = !vld_q || out_ready;
  assign in_ready  = (left_q == '0) && slot_free;
  assign take      = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      hold_q <= '0;
      left_q <= '0;
      sel_q  <= '0;
      vld_q  <= 1'b0;
      dat_q  <= '0;
    end else begin
      acc_q <= take ? updated : base;
      if (take) begin
        vld_q <= 1'b1;
        dat_q <= in_data;
        if (in_send_check) begin
          hold_q <= updated;
          left_q <= is_crc(kind) ? CW'(NB) : CW'(1);
          sel_q  <= '0;
        end
      end else if ((left_q != '0) && slot_free) begin
        vld_q  <= 1'b1;
        dat_q  <= hold_q[sel_q*DATA_W +: DATA_W];
        left_q <= left_q - 1'b1;
        sel_q  <= sel_q + 1'b1;
      end else if (out_ready) begin
        vld_q <= 1'b0;
      end
    end
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;
endmodule

// File: rtl/bcc_rx.sv
module bcc_rx
  import bcc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CRC_W  = 16,
  parameter logic [CRC_W-1:0] POLY_A = 16'h8005,
  parameter logic [CRC_W-1:0] POLY_B = 16'h1021
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        kind,
  input  logic              clear,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_include,
  input  logic              in_expect,
  output logic              ok,
  output logic              err
);
  localparam int NB = CRC_W / DATA_W;
  localparam int CW = $clog2(NB + 1);

  logic [CRC_W-1:0] acc_q, hold_q, base, stepped, updated;
  logic [CW-1:0]    left_q, sel_q;
  logic             bad_q, ok_q, err_q, miss, fresh;

  assign base = clear ? '0 : acc_q;

  bcc_step #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY_A(POLY_A), .POLY_B(POLY_B)) u_step (
    .kind   (kind),
    .acc_in (base),
    .ch     (in_data),
    .acc_out(stepped)
  );

  assign updated = in_include ? stepped : base;
  assign miss    = in_data != hold_q[sel_q*DATA_W +: DATA_W];
  assign fresh   = clear || (left_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      hold_q <= '0;
      left_q <= '0;
      sel_q  <= '0;
      bad_q  <= 1'b0;
      ok_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      ok_q  <= 1'b0;
      err_q <= 1'b0;
      if (in_valid && fresh) begin
        acc_q <= updated;
        if (in_expect) begin
          hold_q <= updated;
          left_q <= is_crc(kind) ? CW'(NB) : CW'(1);
          sel_q  <= '0;
          bad_q  <= 1'b0;
        end else begin
          left_q <= '0;
        end
      end else if (in_valid) begin
        left_q <= left_q - 1'b1;
        sel_q  <= sel_q + 1'b1;
        bad_q  <= bad_q || miss;
        if (left_q == CW'(1)) begin
          ok_q  <= !(bad_q || miss);
          err_q <= bad_q || miss;
        end
      end else begin
        acc_q <= base;
        if (clear) left_q <= '0;
      end
    end
  end

  assign ok  = ok_q;
  assign err = err_q;
endmodule

// File: rtl/bcc_engine.sv
module bcc_engine
  import bcc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CRC_W  = 16,
  parameter logic [CRC_W-1:0] POLY_A = 16'h8005,
  parameter logic [CRC_W-1:0] POLY_B = 16'h1021
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        chk_kind,
  input  logic              tx_clear,
  input  logic              tx_in_valid,
  output logic              tx_in_ready,
  input  logic [DATA_W-1:0] tx_in_data,
  input  logic              tx_in_include,
  input  logic              tx_in_send_check,
  output logic              tx_out_valid,
  input  logic              tx_out_ready,
  output logic [DATA_W-1:0] tx_out_data,
  input  logic              rx_clear,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_include,
  input  logic              rx_expect,
  output logic              check_ok,
  output logic              check_err
);
  bcc_tx #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY_A(POLY_A), .POLY_B(POLY_B)) u_tx (
    .clk          (clk),
    .rst_n        (rst_n),
    .kind         (chk_kind),
    .clear        (tx_clear),
    .in_valid     (tx_in_valid),
    .in_ready     (tx_in_ready),
    .in_data      (tx_in_data),
    .in_include   (tx_in_include),
    .in_send_check(tx_in_send_check),
    .out_valid    (tx_out_valid),
    .out_ready    (tx_out_ready),
    .out_data     (tx_out_data)
  );

  bcc_rx #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY_A(POLY_A), .POLY_B(POLY_B)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .kind      (chk_kind),
    .clear     (rx_clear),
    .in_valid  (rx_valid),
    .in_data   (rx_data),
    .in_include(rx_include),
    .in_expect (rx_expect),
    .ok        (check_ok),
    .err       (check_err)
  );

  assign rx_ready = 1'b1;
endmodule

// File: rtl/bcc_engine_chk.sv
module bcc_engine_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_in_valid,
  input logic              tx_in_ready,
  input logic              tx_in_send_check,
  input logic              tx_out_valid,
  input logic              tx_out_ready,
  input logic [DATA_W-1:0] tx_out_data,
  input logic              rx_valid,
  input logic              check_ok,
  input logic              check_err
);
  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_out_valid && !tx_out_ready) |=> (tx_out_valid && $stable(tx_out_data)));

  // R4
  append_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_in_valid && tx_in_ready && tx_in_send_check) |=> !tx_in_ready);

  // R8
  verdict_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(check_ok && check_err));

  // R8
  verdict_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (check_ok || check_err) |=> !(check_ok || check_err));

  // R8
  verdict_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (check_ok || check_err) |-> $past(rx_valid));
endmodule

bind bcc_engine bcc_engine_chk #(.DATA_W(DATA_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .tx_in_valid     (tx_in_valid),
  .tx_in_ready     (tx_in_ready),
  .tx_in_send_check(tx_in_send_check),
  .tx_out_valid    (tx_out_valid),
  .tx_out_ready    (tx_out_ready),
  .tx_out_data     (tx_out_data),
  .rx_valid        (rx_valid),
  .check_ok        (check_ok),
  .check_err       (check_err)
);

// File: tb/bcc_engine_bench.sv
`timescale 1ns/1ps
module bcc_engine_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [1:0] chk_kind = 2'b00;
  logic       tx_clear = 1'b0, tx_in_valid = 1'b0, tx_in_include = 1'b0, tx_in_send_check = 1'b0;
  logic [7:0] tx_in_data = 8'h00;
  logic       tx_in_ready, tx_out_valid;
  logic       tx_out_ready = 1'b1;
  logic [7:0] tx_out_data;
  logic       rx_clear = 1'b0, rx_valid = 1'b0, rx_include = 1'b0, rx_expect = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       rx_ready, check_ok, check_err;

  bcc_engine u_bcc_engine (
    .clk(clk), .rst_n(rst_n), .chk_kind(chk_kind),
    .tx_clear(tx_clear), .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready),
    .tx_in_data(tx_in_data), .tx_in_include(tx_in_include), .tx_in_send_check(tx_in_send_check),
    .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
    .rx_clear(rx_clear), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_include(rx_include), .rx_expect(rx_expect), .check_ok(check_ok), .check_err(check_err)
  );

  int total = 0;
  int bad = 0;
  int stall_mode = 0;
  int rdy_ctr = 0;
  logic [7:0]  got_q[$];
  logic [7:0]  exp_q[$];
  logic [15:0] tx_model = 16'h0;
  logic [15:0] rx_model = 16'h0;
  logic        was_stalled = 1'b0;
  logic [7:0]  stalled_data = 8'h00;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // reflected CRC / XOR reference, one bit at a time
  function automatic logic [15:0] mstep(input logic [1:0] k, input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic fb;
    r = c;
    if (k == 2'b01 || k == 2'b10) begin
      for (int b = 0; b < 8; b++) begin
        fb = r[0] ^ d[b];
        r  = r >> 1;
        if (fb) r = r ^ ((k == 2'b01) ? 16'hA001 : 16'h8408);
      end
    end else begin
      r[7:0] = r[7:0] ^ d;
    end
    return r;
  endfunction

  // consumer ready pattern
  initial begin
    forever begin
      @(posedge clk);
      #1;
      rdy_ctr++;
      tx_out_ready = (stall_mode == 0) ? 1'b1 : ((rdy_ctr % 3) != 0);
    end
  end

  // output monitor and R5 hold check
  always @(negedge clk) begin
    if (rst_n) begin
      if (was_stalled) begin
        chk("R5 valid held", int'(tx_out_valid), 1);
        chk("R5 data held", int'(tx_out_data), int'(stalled_data));
      end
      was_stalled = tx_out_valid && !tx_out_ready;
      stalled_data = tx_out_data;
      if (tx_out_valid && tx_out_ready) got_q.push_back(tx_out_data);
    end
  end

  task automatic tx_put(input logic [7:0] d, input logic inc, input logic snd, input logic clr);
    @(posedge clk);
    #1;
    tx_in_valid = 1'b1; tx_in_data = d; tx_in_include = inc;
    tx_in_send_check = snd; tx_clear = clr;
    do @(negedge clk); while (!tx_in_ready);
    @(posedge clk);
    #1;
    tx_in_valid = 1'b0; tx_clear = 1'b0; tx_in_send_check = 1'b0;
  endtask

  task automatic rx_put(input logic [7:0] d, input logic inc, input logic ex, input logic clr);
    @(posedge clk);
    #1;
    rx_valid = 1'b1; rx_data = d; rx_include = inc; rx_expect = ex; rx_clear = clr;
    @(posedge clk);
    #1;
    rx_valid = 1'b0; rx_clear = 1'b0; rx_expect = 1'b0;
  endtask

  // pat: 0 all included, 1 every other, 2 only the last; corrupt: 0 none, 1 low byte, 2 last byte
  task automatic run_block(input logic [1:0] k, input int len, input int pat, input int seed,
                           input int stall, input int corrupt, input logic clr, input logic known);
    logic [7:0] d, cb;
    logic inc;
    int nb, ndata;
    chk_kind = k;
    stall_mode = stall;
    got_q.delete();
    exp_q.delete();
    if (clr) begin tx_model = 16'h0; rx_model = 16'h0; end
    nb = (k == 2'b01 || k == 2'b10) ? 2 : 1;
    for (int i = 0; i < len; i++) begin
      d = known ? 8'(8'h31 + i) : 8'((seed * 37 + i * 91 + 5) & 255);
      inc = (pat == 0) ? 1'b1 : (pat == 1) ? (i % 2 == 0) : (i == len - 1);
      if (inc) tx_model = mstep(k, tx_model, d);
      exp_q.push_back(d);
      tx_put(d, inc, i == len - 1, clr && (i == 0));
    end
    for (int b = 0; b < nb; b++) exp_q.push_back(tx_model[8*b +: 8]);
    repeat (10) @(negedge clk);
    ndata = len;
    chk("R4 byte count", got_q.size(), exp_q.size());
    if (got_q.size() == exp_q.size()) begin
      for (int i = 0; i < exp_q.size(); i++) begin
        if (i < ndata) chk("R3 forwarded data", int'(got_q[i]), int'(exp_q[i]));
        else chk("R1 R2 R4 R6 check byte", int'(got_q[i]), int'(exp_q[i]));
      end
    end
    // receive the same block followed by its check bytes
    for (int i = 0; i < len; i++) begin
      d = known ? 8'(8'h31 + i) : 8'((seed * 37 + i * 91 + 5) & 255);
      inc = (pat == 0) ? 1'b1 : (pat == 1) ? (i % 2 == 0) : (i == len - 1);
      if (inc) rx_model = mstep(k, rx_model, d);
      rx_put(d, inc, i == len - 1, clr && (i == 0));
    end
    for (int b = 0; b < nb; b++) begin
      cb = rx_model[8*b +: 8];
      if ((corrupt == 1 && b == 0) || (corrupt == 2 && b == nb - 1)) cb = cb ^ 8'h5A;
      rx_put(cb, 1'b1, 1'b0, 1'b0);
    end
    @(negedge clk);
    chk("R7 R8 check_ok", int'(check_ok), int'(corrupt == 0));
    chk("R7 R8 check_err", int'(check_err), int'(corrupt != 0));
    @(negedge clk);
    chk("R8 pulse ends", int'(check_ok || check_err), 0);
  endtask

  initial begin
    #(8 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 tx_out_valid in reset", int'(tx_out_valid), 0);
    chk("R9 verdict in reset", int'(check_ok || check_err), 0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 tx_in_ready after reset", int'(tx_in_ready), 1);
    chk("R9 rx_ready", int'(rx_ready), 1);

    // R1 known vectors, no clear: accumulators must start at zero after reset (R9)
    run_block(2'b01, 9, 0, 0, 0, 0, 1'b0, 1'b1);
    chk("R1 CRC-16 of 123456789", int'({got_q[10], got_q[9]}), 16'hBB3D);
    run_block(2'b10, 9, 0, 0, 1, 0, 1'b1, 1'b1);
    chk("R1 CRC-CCITT of 123456789", int'({got_q[10], got_q[9]}), 16'h2189);

    // sweep of types (11 behaves as LRC), lengths, include patterns, stalls and corruption
    for (int k = 0; k < 4; k++) begin
      for (int len = 1; len <= 10; len++) begin
        for (int pat = 0; pat < 3; pat++) begin
          run_block(2'(k), len, pat, k * 31 + len * 7 + pat, len % 2, (len + pat) % 3,
                    !(pat == 1 && len > 1), 1'b0);
        end
      end
    end
    finish_up();
  end
endmodule